// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block produces the strobes of a multiplexed external memory bus for a small 8-bit controller core. Every count is in oscillator clock periods. The work is divided into slots. A short slot is 6 clocks long and is used for a code fetch or for an idle interval. A long slot is 12 clocks long and is used for a data read or a data write. Each slot opens with a two-clock address-latch pulse (ALE). Because a data access fills two short-slot periods, the ALE pulse that would have fallen in its second half is not issued.

The core offers one request at a time, giving the access kind, the address and the write data. A request is accepted on the clock edge that closes the current slot. The block drives the upper address byte for the whole cycle. It multiplexes the low address byte and the write data onto one shared byte bus, drives the program-store, read and write strobes, and samples the shared bus to capture read data. A one-bit auxiliary register can silence ALE during idle slots, so that a core running from on-chip memory does not toggle the pin. Every external access still produces its ALE pulse.

Top module: `ebc_bus_cycle`

## Requirements
- R1: While rst_n is low, the outputs are at rest: ale=0, psen_n=rd_n=wr_n=1, ad_oe=0, cap_stb=0, rdata_vld=0, rdata=0, a_hi=0. req_ready is 1.
- R2: req_ready is high only in the last cycle of a slot. The request present at that clock edge is taken. req_kind 00 is a code fetch, 01 a data read and 10 a data write. Code 11, or req_valid low, starts a 6-cycle idle slot. Fetch and idle slots last 6 cycles. Read and write slots last 12 cycles.
- R3: In fetch, read, write and idle slots, ale is high in cycles 0 and 1 of the slot and low otherwise. A run of fetch or idle slots therefore pulses ALE every 6 clocks.
- R4: In a fetch slot, ad_out carries address bits 7:0 with ad_oe high in cycles 0 to 2, so it is held one clock after ALE falls. psen_n is low in cycles 3 to 5, three clocks that start one clock after ALE falls.
- R5: In a read slot, rd_n is low in cycles 5 to 10, six clocks that start three clocks after ALE falls. No ALE pulse appears in cycles 6 and 7. The bus is released (ad_oe low) from cycle 3 to the end of the slot.
- R6: In a write slot, wr_n is low in cycles 5 to 10. ad_out carries the write data with ad_oe high from cycle 4 through cycle 11, so the data is valid one clock before the falling edge of wr_n and one clock after its rising edge.
- R7: a_hi carries address bits 15:8 of the last accepted request from cycle 0 of its slot. It holds that value until another request is accepted.
- R8: cap_stb is high in the last low cycle of psen_n (fetch) or rd_n (read). ad_in is sampled at the clock edge that ends that cycle, which is the same edge on which the strobe returns high. The sample appears on rdata with rdata_vld high for exactly the following cycle. rdata keeps its value until the next capture.
- R9: A write with sfr_we=1 and sfr_addr=8EH loads sfr_wbit into the ALE-off bit. While the bit is 1, idle slots keep ale low. Fetch, read and write slots still pulse ALE. The bit is read when a slot starts, so a write affects only slots that start at a later clock edge.
- R10: A write to any sfr_addr other than 8EH leaves the ALE-off bit and the ALE behaviour unchanged.
- R11: At most one of psen_n, rd_n and wr_n is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Last cycle of slot; request taken at the next edge |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wbit | input | 1 | Value written to the ALE-off bit |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| a_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus sampled value |
| cap_stb | output | 1 | Read data capture strobe |
| rdata | output | 8 | Captured read data |
| rdata_vld | output | 1 | rdata updated in previous edge |

## Verification
All pins are registered from a decode of the next slot state. A corrupted slot kind or phase counter therefore appears at the ports within one clock: the next ALE pulse lands in the wrong cycle, or the wrong strobe is asserted. A phase counter that wraps early or late moves req_ready. It also shifts every later strobe, so the per-clock comparison against the bench's own slot model catches the fault at the first slot boundary. A stale ALE-off bit shows as an ALE pulse in an idle slot where none is expected, or a missing one.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int PH_W = 4;
  typedef logic [PH_W-1:0] ph_t;

  localparam ph_t PH_ONE     = 4'd1;
  localparam ph_t LAST_SHORT = 4'd5;
  localparam ph_t LAST_LONG  = 4'd11;
  localparam ph_t ALE_LAST   = 4'd1;
  localparam ph_t ADR_LAST   = 4'd2;
  localparam ph_t FETCH_ON   = 4'd3;
  localparam ph_t FETCH_OFF  = 4'd5;
  localparam ph_t DSTB_ON    = 4'd5;
  localparam ph_t DSTB_OFF   = 4'd10;
  localparam ph_t WDAT_ON    = 4'd4;

  localparam logic [1:0] RK_FETCH = 2'd0;
  localparam logic [1:0] RK_READ  = 2'd1;
  localparam logic [1:0] RK_WRITE = 2'd2;
  localparam logic [1:0] RK_NONE  = 2'd3;

  typedef enum logic [2:0] {SL_IDLE, SL_QUIET, SL_FETCH, SL_READ, SL_WRITE} slot_e;
  typedef enum logic [1:0] {BS_NONE, BS_ADDR, BS_WDATA} bsel_e;

  typedef struct packed {
    logic  ale;
    logic  psen_n;
    logic  rd_n;
    logic  wr_n;
    logic  cap;
    bsel_e sel;
  } strb_t;

  localparam strb_t STRB_REST = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                  wr_n: 1'b1, cap: 1'b0, sel: BS_NONE};

  function automatic ph_t slot_last(slot_e s);
    return (s == SL_READ || s == SL_WRITE) ? LAST_LONG : LAST_SHORT;
  endfunction
endpackage

// File: rtl/ebc_aux_reg.sv
module ebc_aux_reg
  import ebc_pkg::*;
#(
  parameter int          SFR_AW   = 8,
  parameter logic [7:0]  AUX_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_we,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wbit,
  output logic              ale_off
);
  localparam logic [SFR_AW-1:0] HIT = SFR_AW'(AUX_ADDR);

  logic aux_en;
  logic ale_off_q;

  always_comb aux_en = sfr_we && (sfr_addr == HIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ale_off_q <= 1'b0;
    else if (aux_en) ale_off_q <= sfr_wbit;
  end

  assign ale_off = ale_off_q;

  assert_other_addr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr != HIT) |=> $stable(ale_off_q));
  assert_hit_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |=> (ale_off_q == $past(sfr_wbit)));
endmodule

// File: rtl/ebc_slot_seq.sv
module ebc_slot_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              quiet,
  output logic              req_ready,
  output slot_e             slot_nxt,
  output ph_t               ph_nxt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  slot_e slot_q;
  ph_t   ph_q;
  logic  take;

  always_comb begin
    req_ready = (ph_q == slot_last(slot_q));
    take      = req_ready && req_valid && (req_kind != RK_NONE);
    slot_nxt  = slot_q;
    ph_nxt    = ph_q + PH_ONE;
    if (req_ready) begin
      ph_nxt = '0;
      if (take) begin
        case (req_kind)
          RK_FETCH: slot_nxt = SL_FETCH;
          RK_READ:  slot_nxt = SL_READ;
          default:  slot_nxt = SL_WRITE;
        endcase
      end else begin
        slot_nxt = quiet ? SL_QUIET : SL_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SL_IDLE;
      ph_q   <= LAST_SHORT;
    end else begin
      slot_q <= slot_nxt;
      ph_q   <= ph_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q <= slot_last(slot_q));
  assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

// File: rtl/ebc_strobe_dec.sv
module ebc_strobe_dec
  import ebc_pkg::*;
(
  input  slot_e slot,
  input  ph_t   ph,
  output strb_t strb
);
  logic access;

  always_comb begin
    access = (slot == SL_FETCH) || (slot == SL_READ) || (slot == SL_WRITE);
    strb   = STRB_REST;
    if (slot != SL_QUIET && ph <= ALE_LAST) strb.ale = 1'b1;
    if (access && ph <= ADR_LAST)           strb.sel = BS_ADDR;
    case (slot)
      SL_FETCH: begin
        strb.psen_n = !(ph >= FETCH_ON && ph <= FETCH_OFF);
        strb.cap    = (ph == FETCH_OFF);
      end
      SL_READ: begin
        strb.rd_n = !(ph >= DSTB_ON && ph <= DSTB_OFF);
        strb.cap  = (ph == DSTB_OFF);
      end
      SL_WRITE: begin
        strb.wr_n = !(ph >= DSTB_ON && ph <= DSTB_OFF);
        if (ph >= WDAT_ON) strb.sel = BS_WDATA;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ebc_bus_cycle.sv
module ebc_bus_cycle
  import ebc_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         DATA_W   = 8,
  parameter int         SFR_AW   = 8,
  parameter logic [7:0] AUX_ADDR = 8'h8E
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [1:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ready,
  input  logic                     sfr_we,
  input  logic [SFR_AW-1:0]        sfr_addr,
  input  logic                     sfr_wbit,
  output logic                     ale,
  output logic                     psen_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     cap_stb,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdata_vld
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              ale_off;
  slot_e             slot_nxt;
  ph_t               ph_nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  strb_t             strb_nxt;
  strb_t             strb_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvld_q;

  ebc_aux_reg #(.SFR_AW(SFR_AW), .AUX_ADDR(AUX_ADDR)) u_aux (
    .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
    .sfr_wbit(sfr_wbit), .ale_off(ale_off)
  );

  ebc_slot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .quiet(ale_off),
    .req_ready(req_ready), .slot_nxt(slot_nxt), .ph_nxt(ph_nxt),
    .addr_q(addr_q), .wdata_q(wdata_q)
  );

  ebc_strobe_dec u_dec (.slot(slot_nxt), .ph(ph_nxt), .strb(strb_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= STRB_REST;
    else        strb_q <= strb_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= strb_q.cap;
      if (strb_q.cap) rdata_q <= ad_in;
    end
  end

  assign ale       = strb_q.ale;
  assign psen_n    = strb_q.psen_n;
  assign rd_n      = strb_q.rd_n;
  assign wr_n      = strb_q.wr_n;
  assign cap_stb   = strb_q.cap;
  assign ad_oe     = (strb_q.sel != BS_NONE);
  assign ad_out    = (strb_q.sel == BS_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
  assign a_hi      = addr_q[ADDR_W-1 -: HI_W];
  assign rdata     = rdata_q;
  assign rdata_vld = rvld_q;

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  assert_ale_rise_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  assert_ale_max_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale);
  assert_psen_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));
  assert_psen_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);
  assert_rd_after_ale_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> ($past(ale, 4) && !$past(ale, 3)));
  assert_bus_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !ad_oe);
  assert_wr_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || $rose(wr_n) || $fell(wr_n)) |-> ad_oe);
  assert_ahi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && req_valid) |=> $stable(a_hi));
  assert_cap_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |-> (!psen_n || !rd_n));
  assert_cap_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (psen_n && rd_n && rdata_vld));
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> $past(req_ready && (!ale_off || (req_valid && req_kind != RK_NONE))));
endmodule

// File: tb/tb_ebc_bus_cycle.sv
`timescale 1ns/1ps
module tb_ebc_bus_cycle;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic        sfr_we;
  logic [7:0]  sfr_addr;
  logic        sfr_wbit;
  logic        ale, psen_n, rd_n, wr_n, ad_oe, cap_stb, rdata_vld;
  logic [7:0]  a_hi, ad_out, ad_in, rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit run_chk = 0;
  bit done = 0;
  string ale_tag = "R3";
  int adin_cnt = 0;

  always #4 clk = ~clk;

  ebc_bus_cycle dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wbit(sfr_wbit),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .a_hi(a_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .cap_stb(cap_stb),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: kinds 0 idle, 1 quiet idle, 2 fetch, 3 read, 4 write
  int          m_kind, m_ph;
  logic [15:0] m_addr;
  logic [7:0]  m_wd, m_rd;
  bit          m_vld, m_off;

  function automatic int last_of(int k);
    return (k == 3 || k == 4) ? 11 : 5;
  endfunction
  function automatic bit e_ale(int k, int p);
    return (k != 1) && (p < 2);
  endfunction
  function automatic bit e_psen_n(int k, int p);
    return !(k == 2 && p >= 3 && p <= 5);
  endfunction
  function automatic bit e_rd_n(int k, int p);
    return !(k == 3 && p >= 5 && p <= 10);
  endfunction
  function automatic bit e_wr_n(int k, int p);
    return !(k == 4 && p >= 5 && p <= 10);
  endfunction
  function automatic bit e_oe(int k, int p);
    return (k >= 2) && (p <= 2 || (k == 4 && p >= 4));
  endfunction
  function automatic bit e_cap(int k, int p);
    return (k == 2 && p == 5) || (k == 3 && p == 10);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_kind = 0; m_ph = 5; m_addr = '0; m_wd = '0; m_rd = '0; m_vld = 0; m_off = 0;
    end else begin
      m_vld = e_cap(m_kind, m_ph);
      if (m_vld) m_rd = ad_in;
      if (m_ph == last_of(m_kind)) begin
        m_ph = 0;
        if (req_valid && req_kind != 2'b11) begin
          m_kind = 2 + int'(req_kind);
          m_addr = req_addr;
          m_wd   = req_wdata;
        end else begin
          m_kind = m_off ? 1 : 0;
        end
      end else begin
        m_ph++;
      end
      if (sfr_we && sfr_addr == 8'h8E) m_off = sfr_wbit;
    end
  end

  always @(negedge clk) begin
    adin_cnt++;
    ad_in = 8'(adin_cnt * 37 + 11);
  end

  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      chk(req_ready == (m_ph == last_of(m_kind)), "R2", "req_ready", req_ready, m_ph == last_of(m_kind));
      chk(ale == e_ale(m_kind, m_ph), ale_tag, "ale", ale, e_ale(m_kind, m_ph));
      chk(psen_n == e_psen_n(m_kind, m_ph), "R4", "psen_n", psen_n, e_psen_n(m_kind, m_ph));
      chk(rd_n == e_rd_n(m_kind, m_ph), "R5", "rd_n", rd_n, e_rd_n(m_kind, m_ph));
      chk(wr_n == e_wr_n(m_kind, m_ph), "R6", "wr_n", wr_n, e_wr_n(m_kind, m_ph));
      chk(ad_oe == e_oe(m_kind, m_ph), (m_ph > 2) ? "R6" : "R4", "ad_oe", ad_oe, e_oe(m_kind, m_ph));
      if (e_oe(m_kind, m_ph)) begin
        if (m_ph <= 2) chk(ad_out == m_addr[7:0], "R4", "ad_out addr", ad_out, m_addr[7:0]);
        else           chk(ad_out == m_wd, "R6", "ad_out wdata", ad_out, m_wd);
      end
      chk(a_hi == m_addr[15:8], "R7", "a_hi", a_hi, m_addr[15:8]);
      chk(cap_stb == e_cap(m_kind, m_ph), "R8", "cap_stb", cap_stb, e_cap(m_kind, m_ph));
      chk(rdata_vld == m_vld, "R8", "rdata_vld", rdata_vld, m_vld);
      chk(rdata == m_rd, "R8", "rdata", rdata, m_rd);
      chk($countones({~psen_n, ~rd_n, ~wr_n}) <= 1, "R11", "strobes low",
          $countones({~psen_n, ~rd_n, ~wr_n}), 1);
    end
  end

  task automatic access(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic b);
    @(negedge clk);
    sfr_we = 1'b1; sfr_addr = a; sfr_wbit = b;
    @(negedge clk);
    sfr_we = 1'b0; sfr_wbit = ~b;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'b11; req_addr = '0; req_wdata = '0;
    sfr_we = 1'b0; sfr_addr = '0; sfr_wbit = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ale == 1'b0 && psen_n && rd_n && wr_n, "R1", "strobes in reset",
        {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk(!ad_oe && !cap_stb && !rdata_vld, "R1", "oe/cap/vld in reset",
        {ad_oe, cap_stb, rdata_vld}, 0);
    chk(rdata == 8'h00 && a_hi == 8'h00, "R1", "rdata/a_hi in reset", {rdata, a_hi}, 0);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1;
    repeat (14) @(negedge clk);               // idle ALE at 1/6 rate (R3)
    access(2'b00, 16'h12A5, 8'h00);           // fetches back to back (R4)
    access(2'b00, 16'h12A6, 8'h00);
    access(2'b00, 16'hFF00, 8'h00);
    access(2'b01, 16'h8034, 8'h00);           // reads (R5, R8)
    access(2'b01, 16'h0001, 8'h00);
    access(2'b10, 16'hC35A, 8'h9E);           // writes (R6)
    access(2'b10, 16'h00FF, 8'h01);
    access(2'b00, 16'h7777, 8'h00);           // mixed (R2)
    access(2'b10, 16'h4242, 8'hA5);
    access(2'b01, 16'h5A5A, 8'h00);
    access(2'b11, 16'hDEAD, 8'h00);           // kind 11: no access (R2, R7)
    repeat (8) @(negedge clk);
    ale_tag = "R9";
    sfr_write(8'h8E, 1'b1);                   // ALE off (R9)
    repeat (20) @(negedge clk);
    access(2'b00, 16'h3C01, 8'h00);
    access(2'b01, 16'h3C02, 8'h00);
    repeat (14) @(negedge clk);
    ale_tag = "R10";
    sfr_write(8'h8F, 1'b0);                   // other address ignored (R10)
    sfr_write(8'h0E, 1'b0);
    repeat (20) @(negedge clk);
    ale_tag = "R9";
    sfr_write(8'h8E, 1'b0);                   // ALE back on
    repeat (20) @(negedge clk);
    repeat (3) begin
      sfr_write(8'h8E, 1'b1);                 // toggle at various phases
      repeat (4) @(negedge clk);
      access(2'b10, 16'h6161, 8'h3C);
      sfr_write(8'h8E, 1'b0);
      repeat (3) @(negedge clk);
    end
    ale_tag = "R3";
    for (int i = 0; i < 6; i++) access(2'(i % 3), 16'(16'h1000 + i * 257), 8'(i * 29));
    repeat (16) @(negedge clk);
    run_chk = 0;
    finish_run();
  end
endmodule